// File: doc/BRIEF.md
# Host Mailbox Command Buffer

This block is the device-side buffer through which an external host passes command messages to an embedded acquisition processor and collects the replies. The host sees a byte-wide port with three registers: a buffer pointer, a data window and a status register. The buffer memory is shared with a processor-side port. The host first writes the pointer to zero. It then streams a command byte, a message-id byte and the payload bytes through the data window, and raises the request-pending flag. After that it polls the flag until it reads zero, resets the pointer, and reads the reply. The reply is a two-byte header followed by the reply payload, placed from offset 0.

The request-pending flag decides which side owns the buffer. While the flag is clear, only the host may write the memory. While it is set, only the processor may write, and host data writes are dropped. The processor receives a one-cycle pulse when the flag rises. It can read any byte at any time. It ends the transaction with a completion input that clears the flag. The host can also clear the flag itself to abandon a request that is stuck.

Top module: `host_mbox_buf`

## Requirements
- R1: In reset the pointer, the pending flag, `host_rdata`, `req_pulse` and `cpu_rdata` are all zero, and every buffer byte reads as zero.
- R2: Register select values are: 0 = pointer, 1 = data window, 2 = status, 3 = unused. A host write to select 0 loads the pointer. A host read of select 0 returns it. A read of select 3 returns zero.
- R3: A host write to select 1 while the flag is clear stores the byte at the pointer and then advances the pointer by one. The pointer wraps from 255 to 0.
- R4: A host read of select 1 returns the byte at the pointer and advances the pointer by one, with the same wrap. `host_rdata` is registered: it changes in the cycle after the read strobe and holds until the next read. If read and write are asserted in the same cycle, only the write is performed.
- R5: A host write to select 2 copies bit 0 into the pending flag only when bit 1 of the same write is 1. Otherwise the flag is unchanged. A status read returns the flag in bit 0 and zero in every other bit.
- R6: While the pending flag is set, a host write to select 1 changes neither the buffer nor the pointer.
- R7: `req_pulse` is high for exactly one cycle, the first cycle in which `req_pending` reads 1 after being 0.
- R8: `cpu_done` clears the pending flag on the next edge. It wins over a host status write in the same cycle.
- R9: `cpu_rdata` shows the byte at `cpu_addr` one cycle later, at any time. A processor write takes effect only while the flag is set.
- R10: A host status write that clears the flag abandons the request and returns write ownership of the buffer to the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host register read strobe |
| host_wr | input | 1 | Host register write strobe |
| host_reg | input | 2 | Host register select |
| host_wdata | input | DW | Host write byte |
| host_rdata | output | DW | Host read byte, registered |
| req_pending | output | 1 | Request-pending flag |
| req_pulse | output | 1 | One-cycle pulse on a new request |
| cpu_addr | input | AW | Processor buffer address |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | DW | Processor write byte |
| cpu_rdata | output | DW | Processor read byte, registered |
| cpu_done | input | 1 | Processor completion, clears the flag |

## Verification
A pointer that slips by one shows up at the host at the next data read as a byte shifted from its neighbour. It also shows up at the next pointer read, both a cycle after the strobe. A wrong ownership state shows up as a request byte overwritten while pending, or as a reply byte that never lands. Either appears on `cpu_rdata` or `host_rdata` within one cycle of the next access to that byte. A bad flag update is visible on `req_pending` and `req_pulse` on the very next edge. For that reason the model compares every output on every cycle.

// File: rtl/host_mbox_buf.sv
module host_mbox_buf #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [1:0]    host_reg,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          req_pending,
  output logic          req_pulse,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          cpu_done
);
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] SEL_PTR = 2'd0;
  localparam logic [1:0] SEL_DAT = 2'd1;
  localparam logic [1:0] SEL_STA = 2'd2;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [DW-1:0] rd_mux;

  wire wr_ptr  = host_wr && host_reg == SEL_PTR;
  wire wr_dat  = host_wr && host_reg == SEL_DAT && !req_pending;
  wire wr_sta  = host_wr && host_reg == SEL_STA && host_wdata[1];
  wire rd_any  = host_rd && !host_wr;
  wire rd_dat  = rd_any && host_reg == SEL_DAT;
  wire set_req = wr_sta && host_wdata[0] && !req_pending && !cpu_done;
  wire cpu_we  = cpu_wr && req_pending;

  always_comb begin
    case (host_reg)
      SEL_PTR: rd_mux = DW'(ptr);
      SEL_DAT: rd_mux = mem[ptr];
      SEL_STA: rd_mux = DW'(req_pending);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr        <= '0;
      host_rdata <= '0;
    end else if (wr_ptr) begin
      ptr <= host_wdata[AW-1:0];
    end else if (wr_dat || rd_dat) begin
      ptr <= ptr + 1'b1;
      if (rd_dat) host_rdata <= rd_mux;
    end else if (rd_any) begin
      host_rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_dat) begin
      mem[ptr] <= host_wdata;
    end else if (cpu_we) begin
      mem[cpu_addr] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_pending <= 1'b0;
      req_pulse   <= 1'b0;
      cpu_rdata   <= '0;
    end else begin
      req_pulse <= set_req;
      cpu_rdata <= mem[cpu_addr];
      if (cpu_done)    req_pending <= 1'b0;
      else if (wr_sta) req_pending <= host_wdata[0];
    end
  end

  // R5
  pend_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_pending) |-> $past(host_wr && host_reg == SEL_STA && host_wdata[1] && host_wdata[0]));

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !req_pending);

  // R7
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |=> !req_pulse);

  // R7
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |-> req_pending);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_reg == SEL_DAT && !req_pending) |=> ptr == $past(ptr) + 1'b1);

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_reg == SEL_DAT && req_pending) |=> $stable(ptr));
endmodule

// File: tb/host_mbox_buf_test.sv
module host_mbox_buf_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic host_rd = 0, host_wr = 0, cpu_wr = 0, cpu_done = 0;
  logic [1:0] host_reg = 0;
  logic [7:0] host_wdata = 0, cpu_addr = 0, cpu_wdata = 0;
  logic [7:0] host_rdata, cpu_rdata;
  logic req_pending, req_pulse;

  int checks = 0, errors = 0;
  logic [7:0] m_mem [256];
  logic [7:0] m_ptr = 0, m_hrd = 0, m_crd = 0;
  logic m_pend = 0, m_pulse = 0;

  host_mbox_buf uut (.clk, .rst_n, .host_rd, .host_wr, .host_reg, .host_wdata,
    .host_rdata, .req_pending, .req_pulse, .cpu_addr, .cpu_wr, .cpu_wdata,
    .cpu_rdata, .cpu_done);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic pend_old;
    pend_old = m_pend;
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_ptr = 0; m_hrd = 0; m_crd = 0; m_pend = 0; m_pulse = 0;
      return;
    end
    m_crd = m_mem[cpu_addr];
    m_pulse = 0;
    if (host_wr) begin
      if (host_reg == 0) m_ptr = host_wdata;
      else if (host_reg == 1 && !pend_old) begin
        m_mem[m_ptr] = host_wdata;
        m_ptr = m_ptr + 1;
      end else if (host_reg == 2 && host_wdata[1] && !cpu_done) begin
        if (host_wdata[0] && !pend_old) m_pulse = 1;
        m_pend = host_wdata[0];
      end
    end else if (host_rd) begin
      case (host_reg)
        0: m_hrd = m_ptr;
        1: begin m_hrd = m_mem[m_ptr]; m_ptr = m_ptr + 1; end
        2: m_hrd = {7'b0, pend_old};
        default: m_hrd = 0;
      endcase
    end
    if (cpu_done) m_pend = 0;
    if (cpu_wr && pend_old) m_mem[cpu_addr] = cpu_wdata;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "host_rdata", host_rdata, m_hrd);
    chk(tag, "cpu_rdata", cpu_rdata, m_crd);
    chk(tag, "req_pending", {7'b0, req_pending}, {7'b0, m_pend});
    chk(tag, "req_pulse", {7'b0, req_pulse}, {7'b0, m_pulse});
  endtask

  task automatic hwrite(logic [1:0] r, logic [7:0] d, string tag);
    host_wr = 1; host_reg = r; host_wdata = d;
    step(tag);
    host_wr = 0;
  endtask

  task automatic hread(logic [1:0] r, string tag);
    host_rd = 1; host_reg = r;
    step(tag);
    host_rd = 0;
  endtask

  task automatic cwrite(logic [7:0] a, logic [7:0] d, string tag);
    cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    step(tag);
    cpu_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step("R1"); step("R1");
    rst_n = 1;
    step("R1");
    // R2 pointer load and readback, unused select
    hwrite(0, 8'h00, "R2");
    hread(0, "R2");
    hread(3, "R2");
    // R3 request message: command, message id, payload
    hwrite(1, 8'h0A, "R3");
    hwrite(1, 8'h5C, "R3");
    for (int i = 0; i < 4; i++) hwrite(1, 8'h30 + 8'(i), "R3");
    hread(0, "R2");
    // R5 status write without load enable leaves flag
    hwrite(2, 8'h01, "R5");
    hread(2, "R5");
    // R7 raise request
    hwrite(2, 8'h03, "R7");
    step("R7");
    hread(2, "R5");
    // R6 data write ignored while pending
    hwrite(0, 8'h01, "R6");
    hwrite(1, 8'hEE, "R6");
    hread(0, "R6");
    // R9 processor reads the request and writes a reply
    for (int i = 0; i < 6; i++) begin
      cpu_addr = 8'(i);
      step("R9");
    end
    cwrite(0, 8'h0A, "R9");
    cwrite(1, 8'h5C, "R9");
    cwrite(2, 8'hA5, "R9");
    // R8 done beats a simultaneous host set
    cpu_done = 1;
    hwrite(2, 8'h03, "R8");
    cpu_done = 0;
    step("R8");
    hread(2, "R8");
    // R9 processor write ignored while not pending
    cwrite(3, 8'h77, "R9");
    // R4 read back the reply
    hwrite(0, 8'h00, "R4");
    for (int i = 0; i < 5; i++) hread(1, "R4");
    step("R4");
    // R4 read and write together act as write
    host_rd = 1;
    hwrite(0, 8'h10, "R4");
    host_rd = 0;
    hread(0, "R4");
    // R3 R4 wrap
    hwrite(0, 8'hFE, "R3");
    for (int i = 0; i < 3; i++) hwrite(1, 8'hC0 + 8'(i), "R3");
    hread(0, "R3");
    hwrite(0, 8'hFE, "R4");
    for (int i = 0; i < 3; i++) hread(1, "R4");
    hread(0, "R4");
    // R10 host abandons a request
    hwrite(2, 8'h03, "R10");
    hwrite(2, 8'h02, "R10");
    hwrite(0, 8'h20, "R10");
    hwrite(1, 8'h99, "R10");
    cwrite(8'h20, 8'h11, "R10");
    hwrite(0, 8'h20, "R10");
    hread(1, "R10");
    cpu_addr = 8'h20;
    step("R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule